// File: doc/BRIEF.md
# Sync-Locked Oscillator Trim Controller

This block keeps a free-running fast oscillator near its target frequency. A 1 kHz frame-start strobe, already decoded to one clock cycle, serves as the timing reference. Between two strobes a signed down-counter counts cycles of the fast clock, starting from a programmable reload value. The value the counter holds when the next strobe arrives is the frequency error. Its magnitude is compared with a programmable limit. The result sorts each period into one of three bands (in tolerance, drifting, out of range). In the drifting band the 6-bit trim code moves one step toward the target.

For a 48 MHz oscillator against a 1 kHz reference, software programs the reload to 47999, which is the clock ratio minus one, and the limit to 34. A control write holds three things: a counter-enable bit, an automatic-trim bit, and a trim value that is loaded only while automatic trimming is off. If no strobe arrives within the limit window, the counter stops at a floor and a missed-sync flag goes high.

Top module: `sof_trim_ctrl`

## Requirements
- R1: After reset the trim code is 32, all four status flags are 0, and the error magnitude and sign outputs are 0.
- R2: A configuration write sets the reload from `cfg_wdata[15:0]` and the limit from `cfg_wdata[23:16]`. When a strobe arrives P clock cycles after the previous one, the captured signed error equals reload − (P − 1). `err_count` shows its magnitude, and `err_neg` is 1 when the error is negative (strobe late, oscillator fast).
- R3: A captured magnitude below the limit sets `sync_ok` and leaves the trim unchanged.
- R4: A magnitude at or above the limit and below twice the limit sets `sync_warn`. With automatic trim on, the trim code moves by one: up for a positive error, down for a negative one.
- R5: A magnitude at or above twice the limit sets `sync_err` and leaves the trim unchanged.
- R6: Each capture replaces the band flags, and at most one of `sync_ok`, `sync_warn`, `sync_err` is high at a time.
- R7: When the counter reaches minus twice the limit with no strobe, `sync_miss` rises and the counter holds there. The next strobe then captures a magnitude of twice the limit and clears `sync_miss`.
- R8: Automatic steps saturate: the trim code stays at 63 on an upward step and at 0 on a downward step.
- R9: The control word is laid out as bit 0 counter enable, bit 1 automatic trim, and bits 7:2 trim value. A control write with bit 1 clear loads the trim value. A write with bit 1 set ignores the trim value. While automatic trim is off, no capture changes the trim.
- R10: While the counter enable is 0, strobes cause no capture and all outputs hold. The first strobe after enabling only starts a measurement period and reports nothing.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_in | input | 1 | Decoded single-cycle frame-start strobe |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 24 | Reload [15:0], limit [23:16] |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Enable [0], automatic trim [1], trim value [7:2] |
| trim_code | output | 6 | Oscillator trim code |
| sync_ok | output | 1 | Last period within the limit |
| sync_warn | output | 1 | Last period in the stepping band |
| sync_err | output | 1 | Last period beyond twice the limit |
| sync_miss | output | 1 | Counter reached its floor with no strobe |
| err_count | output | 18 | Magnitude of the last captured error |
| err_neg | output | 1 | Sign of the last captured error (1 = negative) |

## Verification
A miscounted period appears at the strobe edge after the fault. `err_count` is wrong by the same number of cycles, and the band flags may flip. A wrong step direction or a broken saturation shows on `trim_code` at that same edge. A counter that runs past its floor or misses the floor leaves `sync_miss` wrong before the strobe, and the next capture then reports a magnitude other than twice the limit. Faults in arming or enable handling show as a capture on the first strobe after enabling, or on any strobe while disabled.

// File: rtl/sof_trim_pkg.sv
package sof_trim_pkg;
  localparam int RLD_W  = 16;
  localparam int LIM_W  = 8;
  localparam int TRIM_W = 6;
  localparam int CNT_W  = RLD_W + 2;

  typedef logic signed [CNT_W-1:0] cnt_t;
  typedef logic        [CNT_W-1:0] mag_t;
  typedef logic        [TRIM_W-1:0] trim_t;

  typedef enum logic [1:0] {
    CLS_OK   = 2'd0,
    CLS_WARN = 2'd1,
    CLS_ERR  = 2'd2
  } cls_e;

  localparam trim_t TRIM_MAX = '1;
  localparam trim_t TRIM_MID = trim_t'(1) << (TRIM_W - 1);

  // Lowest value the period counter may reach: minus twice the limit.
  function automatic cnt_t floor_of(input logic [LIM_W-1:0] lim);
    cnt_t twice;
    twice = {{(CNT_W-LIM_W-1){1'b0}}, lim, 1'b0};
    return -twice;
  endfunction

  function automatic mag_t mag_of(input cnt_t c);
    return c[CNT_W-1] ? mag_t'(-c) : mag_t'(c);
  endfunction

  function automatic cls_e classify(input mag_t m, input logic [LIM_W-1:0] lim);
    mag_t lo;
    mag_t hi;
    lo = {{(CNT_W-LIM_W){1'b0}}, lim};
    hi = {{(CNT_W-LIM_W-1){1'b0}}, lim, 1'b0};
    if (m < lo)      return CLS_OK;
    else if (m < hi) return CLS_WARN;
    else             return CLS_ERR;
  endfunction

  function automatic trim_t trim_next(input trim_t t, input logic up);
    if (up) return (t == TRIM_MAX) ? t : t + trim_t'(1);
    else    return (t == '0) ? t : t - trim_t'(1);
  endfunction
endpackage

// File: rtl/sof_period_counter.sv
module sof_period_counter
  import sof_trim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             sync_evt,
  input  logic [RLD_W-1:0] reload,
  input  cnt_t             floor_val,
  output cnt_t             cnt_q,
  output logic             armed_q,
  output logic             at_floor
);
  cnt_t start_val;

  assign start_val = {{(CNT_W-RLD_W){1'b0}}, reload};
  assign at_floor  = armed_q && (cnt_q == floor_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (!run) begin
      cnt_q   <= start_val;
      armed_q <= 1'b0;
    end else if (sync_evt) begin
      cnt_q   <= start_val;
      armed_q <= 1'b1;
    end else if (armed_q && !at_floor) begin
      cnt_q   <= cnt_q - cnt_t'(1);
    end
  end
endmodule

// File: rtl/sof_err_eval.sv
module sof_err_eval
  import sof_trim_pkg::*;
(
  input  cnt_t             cnt,
  input  logic [LIM_W-1:0] lim,
  output mag_t             mag,
  output logic             neg,
  output cls_e             cls
);
  always_comb begin
    mag = mag_of(cnt);
    neg = cnt[CNT_W-1];
    cls = classify(mag, lim);
  end
endmodule

// File: rtl/sof_trim_reg.sv
module sof_trim_reg
  import sof_trim_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step_vld,
  input  logic  step_up,
  input  logic  load_vld,
  input  trim_t load_val,
  output trim_t trim_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        trim_q <= TRIM_MID;
    else if (load_vld) trim_q <= load_val;
    else if (step_vld) trim_q <= trim_next(trim_q, step_up);
  end
endmodule

// File: rtl/sof_trim_ctrl.sv
module sof_trim_ctrl
  import sof_trim_pkg::*;
#(
  parameter logic [RLD_W-1:0] RELOAD_RST = 16'd47999,
  parameter logic [LIM_W-1:0] LIMIT_RST  = 8'h22
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sync_in,
  input  logic                     cfg_wr,
  input  logic [RLD_W+LIM_W-1:0]   cfg_wdata,
  input  logic                     ctl_wr,
  input  logic [TRIM_W+1:0]        ctl_wdata,
  output logic [TRIM_W-1:0]        trim_code,
  output logic                     sync_ok,
  output logic                     sync_warn,
  output logic                     sync_err,
  output logic                     sync_miss,
  output logic [CNT_W-1:0]         err_count,
  output logic                     err_neg
);
  localparam int CTL_EN   = 0;
  localparam int CTL_AUTO = 1;
  localparam int CTL_TRIM = 2;

  logic [RLD_W-1:0] reload_q;
  logic [LIM_W-1:0] limit_q;
  logic             cnt_en_q;
  logic             auto_q;

  cnt_t cnt_q;
  cnt_t floor_val;
  logic armed_q;
  logic at_floor;
  mag_t mag;
  logic neg;
  cls_e cls;

  // Named internal events, observed by the checker.
  logic capture;
  logic step_vld;
  logic load_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= RELOAD_RST;
      limit_q  <= LIMIT_RST;
      cnt_en_q <= 1'b0;
      auto_q   <= 1'b0;
    end else begin
      if (cfg_wr) begin
        reload_q <= cfg_wdata[RLD_W-1:0];
        limit_q  <= cfg_wdata[RLD_W +: LIM_W];
      end
      if (ctl_wr) begin
        cnt_en_q <= ctl_wdata[CTL_EN];
        auto_q   <= ctl_wdata[CTL_AUTO];
      end
    end
  end

  assign floor_val = floor_of(limit_q);

  sof_period_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (cnt_en_q),
    .sync_evt  (sync_in),
    .reload    (reload_q),
    .floor_val (floor_val),
    .cnt_q     (cnt_q),
    .armed_q   (armed_q),
    .at_floor  (at_floor)
  );

  sof_err_eval u_eval (
    .cnt (cnt_q),
    .lim (limit_q),
    .mag (mag),
    .neg (neg),
    .cls (cls)
  );

  assign capture  = sync_in && cnt_en_q && armed_q;
  assign step_vld = capture && auto_q && (cls == CLS_WARN);
  assign load_vld = ctl_wr && !ctl_wdata[CTL_AUTO];

  sof_trim_reg u_trim (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_vld (step_vld),
    .step_up  (!neg),
    .load_vld (load_vld),
    .load_val (ctl_wdata[CTL_TRIM +: TRIM_W]),
    .trim_q   (trim_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_ok   <= 1'b0;
      sync_warn <= 1'b0;
      sync_err  <= 1'b0;
      sync_miss <= 1'b0;
      err_count <= '0;
      err_neg   <= 1'b0;
    end else if (capture) begin
      sync_ok   <= (cls == CLS_OK);
      sync_warn <= (cls == CLS_WARN);
      sync_err  <= (cls == CLS_ERR);
      sync_miss <= 1'b0;
      err_count <= mag;
      err_neg   <= neg;
    end else if (at_floor && cnt_en_q) begin
      sync_miss <= 1'b1;
    end
  end
endmodule

// File: rtl/sof_trim_ctrl_chk.sv
module sof_trim_ctrl_chk
  import sof_trim_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic             cfg_wr,
  input logic             auto_q,
  input logic             cnt_en_q,
  input logic             capture,
  input cls_e             cls,
  input logic [TRIM_W-1:0] trim_code,
  input logic             sync_ok,
  input logic             sync_warn,
  input logic             sync_err,
  input logic             sync_miss,
  input logic [CNT_W-1:0] err_count
);
  // R6: band flags never overlap
  a_r6_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sync_ok, sync_warn, sync_err}));

  // R8: without a control write the trim moves by at most one step
  a_r8_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> (trim_code == $past(trim_code)) ||
                (trim_code == $past(trim_code) + 6'd1) ||
                (trim_code == $past(trim_code) - 6'd1));

  // R9: manual mode keeps the trim unless software loads it
  a_r9_manual_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_q && !ctl_wr) |=> $stable(trim_code));

  // R5: an out-of-range period never moves the trim
  a_r5_err_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && cls == CLS_ERR && !ctl_wr) |=> $stable(trim_code));

  // R7: a capture clears the missed-sync flag
  a_r7_miss_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !sync_miss);

  // R10: with counting disabled the captured error holds
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en_q && !ctl_wr && !cfg_wr) |=> $stable(err_count));
endmodule

bind sof_trim_ctrl sof_trim_ctrl_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_wr    (ctl_wr),
  .cfg_wr    (cfg_wr),
  .auto_q    (auto_q),
  .cnt_en_q  (cnt_en_q),
  .capture   (capture),
  .cls       (cls),
  .trim_code (trim_code),
  .sync_ok   (sync_ok),
  .sync_warn (sync_warn),
  .sync_err  (sync_err),
  .sync_miss (sync_miss),
  .err_count (err_count)
);

// File: tb/sof_trim_ctrl_tb.sv
`timescale 1ns/1ps
module sof_trim_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_in = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [23:0] cfg_wdata = '0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [5:0]  trim_code;
  logic        sync_ok, sync_warn, sync_err, sync_miss;
  logic [17:0] err_count;
  logic        err_neg;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sof_trim_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .trim_code(trim_code), .sync_ok(sync_ok), .sync_warn(sync_warn),
    .sync_err(sync_err), .sync_miss(sync_miss),
    .err_count(err_count), .err_neg(err_neg)
  );

  // Test settings: reload 99 (100-cycle ideal period), limit 4.
  localparam int RELOAD = 99;
  localparam int LIMIT  = 4;

  localparam int N_VEC = 9;
  localparam int V_PER [N_VEC] = '{100, 102, 106, 95, 97, 104, 93, 92, 110};
  localparam int V_ERR [N_VEC] = '{0,   -2,  -6,  5,  3,  -4,  7,  8,  -8};
  localparam int V_CLS [N_VEC] = '{0,   0,   1,   1,  0,  1,   1,  2,  2};
  localparam int V_TRM [N_VEC] = '{32,  32,  31,  32, 32, 31,  32, 32, 32};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input int rld, input int lim);
    cfg_wdata = {8'(lim), 16'(rld)};
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wr_ctl(input int trim, input bit auto_on, input bit en);
    ctl_wdata = {6'(trim), auto_on, en};
    ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic pulse();
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
  endtask

  // Strobe P cycles after the previous one; returns the miss flag seen just before it.
  task automatic period(input int p, output bit miss_before);
    repeat (p - 1) @(negedge clk);
    miss_before = sync_miss;
    pulse();
  endtask

  function automatic int cls_of_flags();
    return sync_ok ? 0 : sync_warn ? 1 : sync_err ? 2 : 3;
  endfunction

  initial begin
    bit mb;
    int held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    chk("R1 trim", int'(trim_code), 32);
    chk("R1 flags", int'({sync_ok, sync_warn, sync_err, sync_miss}), 0);
    chk("R1 err_count", int'(err_count), 0);
    chk("R1 err_neg", int'(err_neg), 0);

    wr_cfg(RELOAD, LIMIT);
    wr_ctl(5, 1'b1, 1'b1);
    chk("R9 trim field ignored with auto on", int'(trim_code), 32);
    pulse();
    chk("R10 arming strobe reports nothing", int'({sync_ok, sync_warn, sync_err}), 0);

    for (int i = 0; i < N_VEC; i++) begin
      period(V_PER[i], mb);
      chk("R7 miss before strobe", int'(mb), (V_PER[i] >= 109) ? 1 : 0);
      chk("R2 magnitude", int'(err_count), (V_ERR[i] < 0) ? -V_ERR[i] : V_ERR[i]);
      chk("R2 sign", int'(err_neg), (V_ERR[i] < 0) ? 1 : 0);
      chk(V_CLS[i] == 0 ? "R3 band" : V_CLS[i] == 1 ? "R4 band" : "R5 band",
          cls_of_flags(), V_CLS[i]);
      chk("R6 one flag", $countones({sync_ok, sync_warn, sync_err}), 1);
      chk(V_CLS[i] == 1 ? "R4 trim step" : "R3 R5 trim hold", int'(trim_code), V_TRM[i]);
      chk("R7 miss cleared", int'(sync_miss), 0);
    end

    // R9: manual load, and no step while auto is off
    wr_ctl(20, 1'b0, 1'b0);
    chk("R9 manual load", int'(trim_code), 20);
    wr_ctl(20, 1'b0, 1'b1);
    pulse();
    period(106, mb);
    chk("R9 warn seen", int'(sync_warn), 1);
    chk("R9 no step manual", int'(trim_code), 20);

    // R8: saturation at top
    wr_ctl(63, 1'b0, 1'b0);
    wr_ctl(0, 1'b1, 1'b1);
    chk("R8 load 63", int'(trim_code), 63);
    pulse();
    period(95, mb);
    chk("R8 warn up", int'(sync_warn), 1);
    chk("R8 top saturate", int'(trim_code), 63);

    // R8: saturation at bottom
    wr_ctl(0, 1'b0, 1'b0);
    wr_ctl(0, 1'b1, 1'b1);
    pulse();
    period(106, mb);
    chk("R8 warn down", int'(sync_warn), 1);
    chk("R8 bottom saturate", int'(trim_code), 0);
    held = int'(err_count);

    // R10: counting disabled, strobes ignored
    wr_ctl(0, 1'b1, 1'b0);
    pulse();
    period(95, mb);
    period(120, mb);
    chk("R10 err_count held", int'(err_count), held);
    chk("R10 flags held", cls_of_flags(), 1);
    chk("R10 miss stays low", int'(sync_miss), 0);
    chk("R10 trim held", int'(trim_code), 0);

    // R10: first strobe after enable only arms
    wr_ctl(0, 1'b1, 1'b1);
    pulse();
    chk("R10 arm no capture", int'(err_count), held);
    period(100, mb);
    chk("R10 R3 measured after arm", cls_of_flags(), 0);
    chk("R2 exact period", int'(err_count), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule